// File: doc/BRIEF.md
# Command-Stream SPI Master Sequencer

This block turns a byte stream of packed subcommands into activity on a four-wire SPI bus. Every subcommand opens with a header byte. Its two upper bits choose one of four actions: a full-duplex transfer, a transmit-only transfer, a receive-only transfer, or a pause measured in milliseconds. Transmit data follows the header in the stream. A header with a zero length moves no data. Instead it marks the next real transfer so that the chip select stays low after that transfer ends, which joins two transfers into one bus frame.

Bytes captured from the slave leave on a valid/ready output stream in arrival order. When a request finishes, the block gives a one-cycle completion pulse, a count of the bytes it returned, and an error flag.

The input stream marks the last byte of each request. A separate qualifier marks a request that holds no bytes at all. The bus runs SPI mode 0, and the SCK period is a fixed number of system clocks.

Top module: `spi_cmd_seq`

## Requirements
- R1: Header bits [7:6] pick the action: 2'b00 full-duplex, 2'b10 transmit-only, 2'b01 receive-only, 2'b11 delay. For transfers, bits [5:0] give the byte count (1 to 63), and the transmitted bytes follow the header in stream order.
- R2: SCK idles low. Each byte uses eight SCK periods of CLK_DIV system clocks each. MOSI is stable across every rising edge, MISO is sampled on the rising edge, and bits move MSB first.
- R3: SS idles high. It goes low for every transfer with a nonzero count and returns high when that transfer ends, unless R4 applies.
- R4: A transfer header with count zero (0x00, 0x40, 0x80) moves no data. It arms a flag so that the next nonzero transfer leaves SS low at its end, and that transfer then clears the flag. The reference request 82 01 40 85 02 00 02 AA BB 00 83 03 00 01 44 gives frames of 2, 5 and 7 bytes and returns 4 bytes.
- R5: A receive-only transfer drives 0x00 on MOSI for every byte.
- R6: Bytes received during full-duplex and receive-only transfers go to the output stream in order. Bytes received during transmit-only transfers are dropped.
- R7: A delay header's bits [5:0] and the next stream byte form a 14-bit count {hdr[5:0], byte}. The block waits that count times MS_CYCLES clocks, and SCK stays idle during the wait.
- R8: While outValid is high and outReady is low, outData stays constant. No received byte is lost under backpressure.
- R9: After the last subcommand completes and the output has drained, done pulses for one cycle. At that cycle rdCount equals the number of bytes returned for the request.
- R10: A request made of one beat carrying both inEmpty and inLast, as the first beat of a request, completes with err set, moves no bus signal, and has rdCount 0.
- R11: If the stream ends before a subcommand has all its bytes (a transmit byte missing, or a delay low byte missing), the block reports err with done, drives SS high, and accepts a new request afterwards.
- R12: SS is high after every request completes, even when the last transfer was marked to keep it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | 8 | Request stream byte |
| inValid | input | 1 | Request byte valid |
| inLast | input | 1 | Byte ends the request |
| inEmpty | input | 1 | With inLast on a first beat: empty request |
| inReady | output | 1 | Request byte accepted this cycle when valid |
| outData | output | 8 | Received byte |
| outValid | output | 1 | Received byte valid |
| outReady | input | 1 | Consumer takes the received byte |
| done | output | 1 | One-cycle request completion pulse |
| err | output | 1 | Request failed; valid with done |
| rdCount | output | COUNT_W | Bytes returned by the finished request; valid with done |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to slave |
| miso | input | 1 | SPI data from slave |
| ssN | output | 1 | SPI slave select, active low |

## Verification
The hardest case to reach from the ports is the keep-low flag while it is still armed. It has to survive a delay and other intervening headers, and then meet either a second transfer or the end of the request. Only then do the frame boundaries reveal a mistake. The bench builds random requests that mix zero-length headers, short delays and all three transfer kinds, with random backpressure on the output. A bench model predicts the frame lengths, the MOSI bytes and the returned bytes, using a slave whose response depends only on how many bytes came before. Directed requests add the reference sequence, a truncated transmit, a missing delay byte and an empty request.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    OP_XCHG  = 2'b00,
    OP_RECV  = 2'b01,
    OP_SEND  = 2'b10,
    OP_PAUSE = 2'b11
  } seq_op_e;

  // strobes from control to datapath, all single-cycle except delayHi
  typedef struct packed {
    logic       startByte;
    logic       txZero;
    logic       capture;
    logic       ssLow;
    logic       ssHigh;
    logic       startDelay;
    logic [5:0] delayHi;
    logic       clrCount;
    logic       finish;
    logic       finErr;
  } seq_strobe_t;

endpackage

// File: rtl/spi_seq_dp.sv
module spi_seq_dp
  import spi_seq_pkg::*;
#(
  parameter int CLK_DIV   = 64,
  parameter int MS_CYCLES = 16000,
  parameter int COUNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  seq_strobe_t        stb,
  input  logic [7:0]         inData,
  input  logic               miso,
  input  logic               outReady,
  output logic               sck,
  output logic               mosi,
  output logic               ssN,
  output logic [7:0]         outData,
  output logic               outValid,
  output logic [COUNT_W-1:0] rdCount,
  output logic               done,
  output logic               err,
  output logic               byteDone,
  output logic               delayDone
);

  localparam int HALF   = CLK_DIV / 2;
  localparam int HALF_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int MS_W   = (MS_CYCLES > 1) ? $clog2(MS_CYCLES) : 1;

  // ---------------- shift engine ----------------
  logic [HALF_W-1:0] divCnt;
  logic              shBusy;
  logic [2:0]        bitIdx;
  logic [7:0]        txSh;
  logic [7:0]        rxSh;
  logic              capLatch;
  logic              halfTick;

  assign halfTick = shBusy && (divCnt == HALF_W'(HALF - 1));
  assign mosi     = shBusy ? txSh[7] : 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      shBusy   <= 1'b0;
      bitIdx   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      capLatch <= 1'b0;
      sck      <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (stb.startByte) begin
        shBusy   <= 1'b1;
        divCnt   <= '0;
        bitIdx   <= '0;
        txSh     <= stb.txZero ? 8'h00 : inData;
        capLatch <= stb.capture;
        sck      <= 1'b0;
      end else if (shBusy) begin
        if (halfTick) begin
          divCnt <= '0;
          if (!sck) begin
            sck  <= 1'b1;
            rxSh <= {rxSh[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitIdx == 3'd7) begin
              shBusy   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + HALF_W'(1);
        end
      end
    end
  end

  // ---------------- output holding register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      rdCount  <= '0;
    end else begin
      if (byteDone && capLatch) begin
        outValid <= 1'b1;
        outData  <= rxSh;
      end else if (outValid && outReady) begin
        outValid <= 1'b0;
      end
      if (stb.clrCount)
        rdCount <= '0;
      else if (byteDone && capLatch)
        rdCount <= rdCount + COUNT_W'(1);
    end
  end

  // ---------------- millisecond timer ----------------
  logic            dlyBusy;
  logic [13:0]     msLeft;
  logic [MS_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyBusy   <= 1'b0;
      msLeft    <= '0;
      tickCnt   <= '0;
      delayDone <= 1'b0;
    end else begin
      delayDone <= 1'b0;
      if (stb.startDelay) begin
        dlyBusy <= 1'b1;
        msLeft  <= {stb.delayHi, inData};
        tickCnt <= '0;
      end else if (dlyBusy) begin
        if (msLeft == 14'd0) begin
          dlyBusy   <= 1'b0;
          delayDone <= 1'b1;
        end else if (tickCnt == MS_W'(MS_CYCLES - 1)) begin
          tickCnt <= '0;
          msLeft  <= msLeft - 14'd1;
        end else begin
          tickCnt <= tickCnt + MS_W'(1);
        end
      end
    end
  end

  // ---------------- select and completion ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssN  <= 1'b1;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (stb.ssHigh)     ssN <= 1'b1;
      else if (stb.ssLow) ssN <= 1'b0;
      done <= stb.finish;
      err  <= stb.finish && stb.finErr;
    end
  end

  // R3
  ss_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    shBusy |-> !ssN);

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shBusy |-> !sck);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R7
  dly_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlyBusy |-> !shBusy);

  // R9
  done_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  inData,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        inEmpty,
  output logic        inReady,
  input  logic        byteDone,
  input  logic        delayDone,
  input  logic        outBusy,
  output seq_strobe_t stb
);

  typedef enum logic [2:0] {
    S_HDR, S_LOAD, S_RUN, S_DLO, S_DRUN, S_FIN
  } seq_state_e;

  seq_state_e state, stateN;
  seq_op_e    op, opN;
  logic [5:0] remain, remainN;
  logic [5:0] dlyHi, dlyHiN;
  logic       keepSs, keepN;
  logic       lastSeen, lastN;
  logic       firstByte, firstN;
  logic       errFlag, errN;
  seq_op_e    hdrOp;

  assign hdrOp = seq_op_e'(inData[7:6]);

  always_comb begin
    stb         = '0;
    stb.delayHi = dlyHi;
    inReady     = 1'b0;
    stateN      = state;
    opN         = op;
    remainN     = remain;
    dlyHiN      = dlyHi;
    keepN       = keepSs;
    lastN       = lastSeen;
    firstN      = firstByte;
    errN        = errFlag;
    case (state)
      S_HDR: begin
        inReady = 1'b1;
        if (inValid) begin
          lastN  = inLast;
          firstN = 1'b0;
          if (firstByte) stb.clrCount = 1'b1;
          if (firstByte && inEmpty && inLast) begin
            errN   = 1'b1;
            stateN = S_FIN;
          end else if (hdrOp == OP_PAUSE) begin
            dlyHiN = inData[5:0];
            if (inLast) begin
              errN   = 1'b1;
              stateN = S_FIN;
            end else begin
              stateN = S_DLO;
            end
          end else if (inData[5:0] == 6'd0) begin
            keepN = 1'b1;
            if (inLast) stateN = S_FIN;
          end else begin
            opN       = hdrOp;
            remainN   = inData[5:0];
            stb.ssLow = 1'b1;
            stateN    = S_LOAD;
          end
        end
      end
      S_LOAD: begin
        if (op == OP_RECV) begin
          if (!outBusy) begin
            stb.startByte = 1'b1;
            stb.txZero    = 1'b1;
            stb.capture   = 1'b1;
            stateN        = S_RUN;
          end
        end else if (lastSeen) begin
          errN   = 1'b1;
          stateN = S_FIN;
        end else begin
          inReady = (op == OP_SEND) || !outBusy;
          if (inValid && inReady) begin
            lastN         = inLast;
            stb.startByte = 1'b1;
            stb.capture   = (op == OP_XCHG);
            stateN        = S_RUN;
          end
        end
      end
      S_RUN: begin
        if (byteDone) begin
          remainN = remain - 6'd1;
          if (remain == 6'd1) begin
            if (!keepSs) stb.ssHigh = 1'b1;
            keepN  = 1'b0;
            stateN = lastSeen ? S_FIN : S_HDR;
          end else begin
            stateN = S_LOAD;
          end
        end
      end
      S_DLO: begin
        inReady = 1'b1;
        if (inValid) begin
          lastN          = inLast;
          stb.startDelay = 1'b1;
          stateN         = S_DRUN;
        end
      end
      S_DRUN: begin
        if (delayDone) stateN = lastSeen ? S_FIN : S_HDR;
      end
      S_FIN: begin
        if (!outBusy) begin
          stb.ssHigh = 1'b1;
          stb.finish = 1'b1;
          stb.finErr = errFlag;
          stateN     = S_HDR;
          firstN     = 1'b1;
          errN       = 1'b0;
          keepN      = 1'b0;
        end
      end
      default: stateN = S_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_HDR;
      op        <= OP_XCHG;
      remain    <= '0;
      dlyHi     <= '0;
      keepSs    <= 1'b0;
      lastSeen  <= 1'b0;
      firstByte <= 1'b1;
      errFlag   <= 1'b0;
    end else begin
      state     <= stateN;
      op        <= opN;
      remain    <= remainN;
      dlyHi     <= dlyHiN;
      keepSs    <= keepN;
      lastSeen  <= lastN;
      firstByte <= firstN;
      errFlag   <= errN;
    end
  end

  // R11
  trunc_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FIN && !outBusy) |-> stb.ssHigh);

  // R4
  keep_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && byteDone && remain == 6'd1) |=> !keepSs);

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int CLK_DIV   = 64,
  parameter int MS_CYCLES = 16000,
  parameter int COUNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         inData,
  input  logic               inValid,
  input  logic               inLast,
  input  logic               inEmpty,
  output logic               inReady,
  output logic [7:0]         outData,
  output logic               outValid,
  input  logic               outReady,
  output logic               done,
  output logic               err,
  output logic [COUNT_W-1:0] rdCount,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic               ssN
);

  seq_strobe_t stb;
  logic        byteDone;
  logic        delayDone;

  spi_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inData    (inData),
    .inValid   (inValid),
    .inLast    (inLast),
    .inEmpty   (inEmpty),
    .inReady   (inReady),
    .byteDone  (byteDone),
    .delayDone (delayDone),
    .outBusy   (outValid),
    .stb       (stb)
  );

  spi_seq_dp #(
    .CLK_DIV   (CLK_DIV),
    .MS_CYCLES (MS_CYCLES),
    .COUNT_W   (COUNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .inData    (inData),
    .miso      (miso),
    .outReady  (outReady),
    .sck       (sck),
    .mosi      (mosi),
    .ssN       (ssN),
    .outData   (outData),
    .outValid  (outValid),
    .rdCount   (rdCount),
    .done      (done),
    .err       (err),
    .byteDone  (byteDone),
    .delayDone (delayDone)
  );

endmodule

// File: tb/spi_cmd_seq_bench.sv
module spi_cmd_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 8;
  localparam int MS_CYCLES  = 10;
  localparam int COUNT_W    = 8;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inLast = 1'b0, inEmpty = 1'b0;
  logic inReady;
  logic [7:0] outData;
  logic outValid;
  logic outReady = 1'b0;
  logic done, err;
  logic [COUNT_W-1:0] rdCount;
  logic sck, mosi, miso, ssN;

  spi_cmd_seq #(.CLK_DIV(CLK_DIV), .MS_CYCLES(MS_CYCLES), .COUNT_W(COUNT_W)) u_spi_cmd_seq (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inEmpty(inEmpty), .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .done(done), .err(err), .rdCount(rdCount),
    .sck(sck), .mosi(mosi), .miso(miso), .ssN(ssN));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // slave model: answers byte k with a fixed function of k
  function automatic logic [7:0] slaveByte(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  int slaveK = 0, slaveBit = 0, frameBytes = 0, lastRise = 0;
  int periodBad = 0, sckIdleBad = 0;
  bit benchLive = 1'b0;
  logic [7:0] mosiSh = '0;
  logic [7:0] curTx;
  logic [7:0] gotMosi[$], gotRead[$];
  int gotFrames[$];

  assign curTx = slaveByte(slaveK);
  assign miso  = curTx[3'(7 - slaveBit)];

  always @(posedge sck) begin
    mosiSh = {mosiSh[6:0], mosi};
    if (benchLive && slaveBit != 0 && (cyc - lastRise) != CLK_DIV) periodBad++;
    if (benchLive && ssN) sckIdleBad++;
    lastRise = cyc;
  end
  always @(negedge sck) begin
    if (slaveBit == 7) begin
      slaveBit = 0;
      slaveK++;
      gotMosi.push_back(mosiSh);
      frameBytes++;
    end else slaveBit++;
  end
  always @(negedge ssN) frameBytes = 0;
  always @(posedge ssN) if (benchLive && frameBytes > 0) gotFrames.push_back(frameBytes);

  // output consumer and completion monitor
  bit bpMode = 1'b0;
  int doneCnt = 0, doneCyc = 0, doneCount = 0;
  bit doneErr = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      outReady = bpMode ? (($urandom % 3) != 0) : 1'b1;
      if (outValid && outReady) gotRead.push_back(outData);
      if (done) begin
        doneCnt++;
        doneErr   = err;
        doneCount = int'(rdCount);
        doneCyc   = cyc;
      end
    end
  end

  // request builder and expected model
  logic [7:0] reqQ[$], fixQ[$], expMosi[$], expRead[$];
  int expFrames[$];
  int kExp = 0, curFrame = 0, acceptCyc = 0;
  bit keepM = 1'b0, expErr = 1'b0;

  task automatic clearAll();
    reqQ.delete(); expMosi.delete(); expRead.delete(); expFrames.delete();
    gotMosi.delete(); gotRead.delete(); gotFrames.delete();
    curFrame = 0; keepM = 1'b0; expErr = 1'b0;
  endtask

  task automatic addXfer(input logic [1:0] op, input int n);
    reqQ.push_back({op, 6'(n)});
    if (n == 0) keepM = 1'b1;
    else begin
      for (int i = 0; i < n; i++) begin
        logic [7:0] tx;
        tx = (fixQ.size() > 0) ? fixQ.pop_front() : 8'($urandom);
        if (op == 2'b01) tx = 8'h00;
        else reqQ.push_back(tx);
        expMosi.push_back(tx);
        if (op == 2'b00 || op == 2'b01) expRead.push_back(slaveByte(kExp));
        kExp++;
      end
      curFrame += n;
      if (!keepM) begin
        expFrames.push_back(curFrame);
        curFrame = 0;
      end
      keepM = 1'b0;
    end
  endtask

  task automatic addDelay(input logic [13:0] ms);
    reqQ.push_back({2'b11, ms[13:8]});
    reqQ.push_back(ms[7:0]);
  endtask

  task automatic endReq();
    if (curFrame > 0) expFrames.push_back(curFrame);
    curFrame = 0;
    keepM = 1'b0;
  endtask

  task automatic runReq(input bit emptyReq);
    int startDone;
    startDone = doneCnt;
    if (emptyReq) begin
      @(negedge clk);
      inValid = 1'b1; inLast = 1'b1; inEmpty = 1'b1; inData = 8'h00;
      while (!inReady) @(negedge clk);
      @(posedge clk);
    end else begin
      for (int i = 0; i < reqQ.size(); i++) begin
        @(negedge clk);
        inValid = 1'b1; inData = reqQ[i]; inLast = (i == reqQ.size() - 1); inEmpty = 1'b0;
        while (!inReady) @(negedge clk);
        @(posedge clk);
        acceptCyc = cyc;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inEmpty = 1'b0;
    while (doneCnt == startDone) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compareAll(input string tag);
    check(gotFrames.size() == expFrames.size(), {"R3 frame count ", tag}, gotFrames.size(), expFrames.size());
    foreach (expFrames[i])
      if (i < gotFrames.size())
        check(gotFrames[i] == expFrames[i], {"R4 frame length ", tag}, gotFrames[i], expFrames[i]);
    check(gotMosi.size() == expMosi.size(), {"R1 mosi byte count ", tag}, gotMosi.size(), expMosi.size());
    foreach (expMosi[i])
      if (i < gotMosi.size())
        check(gotMosi[i] == expMosi[i], {"R5 mosi byte ", tag}, gotMosi[i], expMosi[i]);
    check(gotRead.size() == expRead.size(), {"R6 read count ", tag}, gotRead.size(), expRead.size());
    foreach (expRead[i])
      if (i < gotRead.size())
        check(gotRead[i] == expRead[i], {"R8 read byte ", tag}, gotRead[i], expRead[i]);
    check(doneCount == expRead.size(), {"R9 rdCount ", tag}, doneCount, expRead.size());
    check(doneErr == expErr, {"R11 err flag ", tag}, doneErr, expErr);
    check(ssN == 1'b1, {"R12 ss released ", tag}, ssN, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    slaveBit = 0; slaveK = 0; frameBytes = 0;
    benchLive = 1'b1;
    @(negedge clk);
    check(ssN == 1'b1, "R3 reset ssN", ssN, 1);
    check(sck == 1'b0, "R2 reset sck", sck, 0);
    check(outValid == 1'b0, "R9 reset outValid", outValid, 0);
    check(done == 1'b0, "R9 reset done", done, 0);
    check(inReady == 1'b1, "R1 reset inReady", inReady, 1);

    // reference sequence
    clearAll();
    fixQ = '{8'h01, 8'h40};                       addXfer(2'b10, 2);
    fixQ = '{8'h02, 8'h00, 8'h02, 8'hAA, 8'hBB};  addXfer(2'b10, 5);
    addXfer(2'b00, 0);
    fixQ = '{8'h03, 8'h00, 8'h01};                addXfer(2'b10, 3);
    addXfer(2'b01, 4);
    endReq();
    check(expFrames.size() == 3 && expFrames[2] == 7, "R4 reference frames model", expFrames.size(), 3);
    runReq(1'b0);
    compareAll("reference");

    // full-duplex with backpressure on a long receive
    clearAll(); bpMode = 1'b1;
    addXfer(2'b00, 3); addXfer(2'b01, 10); endReq();
    runReq(1'b0);
    compareAll("backpressure");
    bpMode = 1'b0;

    // keep flag on the final transfer, released at request end
    clearAll();
    addXfer(2'b10, 0); addXfer(2'b01, 1); endReq();
    runReq(1'b0);
    compareAll("keep at end");

    // delay timing
    clearAll();
    addDelay(14'h102); endReq();
    runReq(1'b0);
    compareAll("delay");
    check((doneCyc - acceptCyc) >= 258 * MS_CYCLES && (doneCyc - acceptCyc) <= 258 * MS_CYCLES + 6,
          "R7 delay length", doneCyc - acceptCyc, 258 * MS_CYCLES);

    // keep flag across a delay
    clearAll();
    addXfer(2'b00, 0); addXfer(2'b10, 2); addDelay(14'd3); addXfer(2'b00, 2); endReq();
    runReq(1'b0);
    compareAll("keep over delay");

    // empty request
    clearAll(); expErr = 1'b1;
    runReq(1'b1);
    compareAll("R10 empty");

    // truncated transmit
    clearAll(); expErr = 1'b1;
    reqQ = '{8'h83, 8'h11};
    expMosi = '{8'h11}; expFrames = '{1}; kExp++;
    runReq(1'b0);
    compareAll("R11 truncated write");

    // truncated delay
    clearAll(); expErr = 1'b1;
    reqQ = '{8'hC0};
    runReq(1'b0);
    compareAll("R11 truncated delay");

    // random requests
    for (int r = 0; r < 30; r++) begin
      int nSub;
      clearAll();
      bpMode = ($urandom % 2) == 1;
      nSub = 1 + ($urandom % 4);
      for (int s = 0; s < nSub; s++) begin
        int op;
        op = $urandom % 4;
        if (op == 3) addDelay(14'($urandom % 3));
        else addXfer(2'(op), $urandom % 5);
      end
      endReq();
      runReq(1'b0);
      compareAll($sformatf("random %0d", r));
    end
    bpMode = 1'b0;

    check(periodBad == 0, "R2 sck period", periodBad, 0);
    check(sckIdleBad == 0, "R2 sck while ss high", sckIdleBad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", WATCHDOG, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule